// File: doc/BRIEF.md
# Ethernet Address Lookup Table Engine

This block keeps a small table of station addresses for a multi-port Ethernet switch and answers forwarding queries against it. Each table entry is a packed record whose low 48 bits hold a MAC address and whose upper bits hold an entry kind plus a set of fields. The meaning of those fields depends on the group bit of the address. A unicast entry names one destination port and carries secure and blocked flags. A multicast entry carries a destination port mask.

Software reaches the table indirectly through a small register window. It stages an entry in three word registers and commits it by writing an index with the write flag set to the command register. Writing an index without the flag copies that entry back into the word registers. A global register enables lookups, starts a table wipe and holds a VLAN-aware mode bit. One register per port holds that port's 2-bit state.

The lookup side takes a destination MAC address with a valid strobe and returns, one cycle later, whether an entry hit, which index hit, and a mask of destination ports. Only ports in the forwarding state appear in the mask. When no entry matches, the mask floods to every forwarding port.

Top module: `alt_lookup_engine`

## Requirements
- R1: After reset the global register, the three staged words and every port state read 0, every table entry is free (all bits 0), and `res_valid` is 0.
- R2: Writing the command register (word address 1) with bit 31 set and an index in bits 7:0 below DEPTH stores the staged words at that index. Word address 4 maps to entry bits 31:0, word address 3 maps to bits 63:32, and word address 2 bits 4:0 map to bits 68:64.
- R3: Writing the command register with bit 31 clear and an in-range index copies that entry into the three staged words. The words can be read back in the next cycle, and the unused upper bits of word address 2 read 0.
- R4: A command whose index is DEPTH or more changes neither the table nor the staged words.
- R5: `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and low otherwise.
- R6: An entry matches when its kind (bits 61:60) is 1 (address) or 3 (VLAN plus address) and its bits 47:0 equal `lk_mac`. Kinds 0 and 2 never match. When several entries match, the lowest index is reported in `res_index`.
- R7: For a matching entry with bit 40 clear (unicast), the mask has only the bit named by the port field (bits 67:66). The mask is empty when the blocked bit (bit 65) is set or the named port is not below NPORTS.
- R8: For a matching entry with bit 40 set (multicast), the mask is taken from bits 68:66, one bit per port.
- R9: Each port state sits in bits 1:0 at word address 8 plus the port number (0 disabled, 1 blocking, 2 learning, 3 forwarding). A port whose state is not 3 is removed from every result mask.
- R10: On a miss, `res_hit` is 0 and the mask holds every port in state 3. While the global enable bit (bit 31 of word address 0) is 0, every lookup is a miss.
- R11: Writing the global register with bit 30 set starts a wipe that sets the kind field of every entry to free, one entry per cycle. The other entry bits are kept. Bit 30 reads 1 for DEPTH cycles after the write and then reads 0. Table commands issued during the wipe are ignored.
- R12: The VLAN-aware bit (bit 2 of word address 0) is stored and reads back, and it has no effect on lookup results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_mac | input | 48 | Destination MAC address to look up |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | An entry matched |
| res_index | output | 4 | Index of the lowest matching entry (0 on a miss) |
| res_mask | output | 3 | Destination ports, filtered by forwarding state |

## Verification
A register write takes effect at the rising edge that samples it. Read data is combinational, so staged words loaded by a reload command can be read just after that same edge. A lookup result is registered once and is due one edge after the request. The bench therefore drives all inputs just after a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. The wipe is checked at two points: busy after the first edge and one cycle before the DEPTH-th edge, and idle right after the DEPTH-th edge. A table write is placed inside the wipe window, after its target index has already been wiped, to show that the write is dropped.

// File: rtl/alt_pkg.sv
package alt_pkg;

    localparam int ADDR_W    = 4;
    localparam int WORD_W    = 32;
    localparam int MAC_W     = 48;
    localparam int ENTRY_W   = 69;
    localparam int HI_W      = ENTRY_W - 2 * WORD_W;
    localparam int CMD_IDX_W = 8;

    localparam logic [ADDR_W-1:0] RA_GLOBAL = 4'd0;
    localparam logic [ADDR_W-1:0] RA_CMD    = 4'd1;
    localparam logic [ADDR_W-1:0] RA_WORD0  = 4'd2;
    localparam logic [ADDR_W-1:0] RA_WORD1  = 4'd3;
    localparam logic [ADDR_W-1:0] RA_WORD2  = 4'd4;
    localparam int                RA_PORT0  = 8;

    localparam int GB_ENABLE = 31;
    localparam int GB_WIPE   = 30;
    localparam int GB_VLAN   = 2;
    localparam int CMD_STORE = 31;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        KIND_FREE      = 2'd0,
        KIND_ADDR      = 2'd1,
        KIND_VLAN      = 2'd2,
        KIND_VLAN_ADDR = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PS_OFF     = 2'd0,
        PS_BLOCK   = 2'd1,
        PS_LEARN   = 2'd2,
        PS_FORWARD = 2'd3
    } pstate_e;

    function automatic kind_e entry_kind(entry_t e);
        return kind_e'(e[61:60]);
    endfunction

    function automatic logic entry_has_addr(entry_t e);
        return (entry_kind(e) == KIND_ADDR) || (entry_kind(e) == KIND_VLAN_ADDR);
    endfunction

    function automatic logic [MAC_W-1:0] entry_mac(entry_t e);
        return e[MAC_W-1:0];
    endfunction

    function automatic logic entry_is_group(entry_t e);
        return e[40];
    endfunction

    function automatic logic [1:0] entry_uc_port(entry_t e);
        return e[67:66];
    endfunction

    function automatic logic entry_uc_blocked(entry_t e);
        return e[65];
    endfunction

    function automatic logic [3:0] entry_mc_mask(entry_t e);
        return {1'b0, e[68:66]};
    endfunction

endpackage

// File: rtl/alt_ctrl.sv
module alt_ctrl
    import alt_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NPORTS = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [WORD_W-1:0]     cfg_wdata,
    output logic [WORD_W-1:0]     cfg_rdata,
    output logic [IDX_W-1:0]      st_rd_idx,
    input  entry_t                st_rd_entry,
    output logic                  st_we,
    output logic [IDX_W-1:0]      st_wr_idx,
    output entry_t                st_wr_entry,
    output logic                  wipe_en,
    output logic [IDX_W-1:0]      wipe_idx,
    output logic                  lookup_en,
    output logic [NPORTS-1:0]     port_fwd
);

    logic [HI_W-1:0]    word0_q;
    logic [WORD_W-1:0]  word1_q;
    logic [WORD_W-1:0]  word2_q;
    logic               enable_q;
    logic               vlan_q;
    logic               wiping_q;
    logic [IDX_W-1:0]   wipe_cnt_q;
    logic [1:0]         pstate_q [NPORTS];

    logic                 cmd_sel;
    logic [CMD_IDX_W-1:0] cmd_idx;
    logic                 cmd_in_range;
    logic                 reload;

    assign cmd_sel      = cfg_we && (cfg_addr == RA_CMD);
    assign cmd_idx      = cfg_wdata[CMD_IDX_W-1:0];
    assign cmd_in_range = ({1'b0, cmd_idx} < (CMD_IDX_W+1)'(DEPTH));
    assign st_we        = cmd_sel &&  cfg_wdata[CMD_STORE] && cmd_in_range && !wiping_q;
    assign reload       = cmd_sel && !cfg_wdata[CMD_STORE] && cmd_in_range && !wiping_q;
    assign st_rd_idx    = cmd_idx[IDX_W-1:0];
    assign st_wr_idx    = cmd_idx[IDX_W-1:0];
    assign st_wr_entry  = {word0_q, word1_q, word2_q};
    assign wipe_en      = wiping_q;
    assign wipe_idx     = wipe_cnt_q;
    assign lookup_en    = enable_q;

    // staged words
    always_ff @(posedge clk) begin
        if (rst) begin
            word0_q <= '0;
            word1_q <= '0;
            word2_q <= '0;
        end else if (reload) begin
            word0_q <= st_rd_entry[ENTRY_W-1:2*WORD_W];
            word1_q <= st_rd_entry[2*WORD_W-1:WORD_W];
            word2_q <= st_rd_entry[WORD_W-1:0];
        end else if (cfg_we) begin
            if (cfg_addr == RA_WORD0) word0_q <= cfg_wdata[HI_W-1:0];
            if (cfg_addr == RA_WORD1) word1_q <= cfg_wdata;
            if (cfg_addr == RA_WORD2) word2_q <= cfg_wdata;
        end
    end

    // global register and wipe sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q   <= 1'b0;
            vlan_q     <= 1'b0;
            wiping_q   <= 1'b0;
            wipe_cnt_q <= '0;
        end else begin
            if (wiping_q) begin
                if (wipe_cnt_q == IDX_W'(DEPTH - 1)) begin
                    wiping_q <= 1'b0;
                end else begin
                    wipe_cnt_q <= wipe_cnt_q + 1'b1;
                end
            end
            if (cfg_we && (cfg_addr == RA_GLOBAL)) begin
                enable_q <= cfg_wdata[GB_ENABLE];
                vlan_q   <= cfg_wdata[GB_VLAN];
                if (cfg_wdata[GB_WIPE] && !wiping_q) begin
                    wiping_q   <= 1'b1;
                    wipe_cnt_q <= '0;
                end
            end
        end
    end

    // per-port state registers
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                pstate_q[p] <= PS_OFF;
            end else if (cfg_we && (cfg_addr == ADDR_W'(RA_PORT0 + p))) begin
                pstate_q[p] <= cfg_wdata[1:0];
            end
        end
        assign port_fwd[p] = (pstate_q[p] == PS_FORWARD);
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RA_GLOBAL: begin
                cfg_rdata[GB_ENABLE] = enable_q;
                cfg_rdata[GB_WIPE]   = wiping_q;
                cfg_rdata[GB_VLAN]   = vlan_q;
            end
            RA_WORD0: cfg_rdata = {{(WORD_W-HI_W){1'b0}}, word0_q};
            RA_WORD1: cfg_rdata = word1_q;
            RA_WORD2: cfg_rdata = word2_q;
            default:  cfg_rdata = '0;
        endcase
        for (int p = 0; p < NPORTS; p++) begin
            if (cfg_addr == ADDR_W'(RA_PORT0 + p)) begin
                cfg_rdata = {30'b0, pstate_q[p]};
            end
        end
    end

    // R11: a wipe always starts from entry 0 and the counter stays in range
    assert_wipe_starts_at_zero_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(wiping_q) |-> (wipe_cnt_q == '0));
    assert_wipe_bounded_R11: assert property (@(posedge clk) disable iff (rst)
        wiping_q |-> ({1'b0, wipe_cnt_q} < (IDX_W+1)'(DEPTH)));
    // R11: the table sees no store while a wipe runs
    assert_no_store_in_wipe_R11: assert property (@(posedge clk) disable iff (rst)
        wiping_q |-> !st_we);

endmodule

// File: rtl/alt_store.sv
module alt_store
    import alt_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  entry_t            wr_entry,
    input  logic              wipe_en,
    input  logic [IDX_W-1:0]  wipe_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output entry_t            rd_entry,
    output entry_t            table_q [DEPTH]
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[i] <= '0;
            end else if (we && (wr_idx == IDX_W'(i))) begin
                table_q[i] <= wr_entry;
            end else if (wipe_en && (wipe_idx == IDX_W'(i))) begin
                table_q[i][61:60] <= KIND_FREE;
            end
        end
    end

    assign rd_entry = table_q[rd_idx];

    // R11: the row named by the wipe counter is free one cycle later
    assert_wipe_frees_row_R11: assert property (@(posedge clk) disable iff (rst)
        (wipe_en && !we) |=> (table_q[$past(wipe_idx)][61:60] == 2'b00));
    // R2: a store lands at its index
    assert_store_lands_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> (table_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/alt_search.sv
module alt_search
    import alt_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  entry_t             table_q [DEPTH],
    input  logic [MAC_W-1:0]   mac,
    input  logic               enable,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output entry_t             hit_entry
);

    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = enable && entry_has_addr(table_q[i]) &&
                          (entry_mac(table_q[i]) == mac);
    end

    // walk from the top down so the lowest matching index is left standing
    always_comb begin
        hit       = 1'b0;
        hit_idx   = '0;
        hit_entry = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                hit_idx   = IDX_W'(i);
                hit_entry = table_q[i];
            end
        end
    end

endmodule

// File: rtl/alt_lookup_engine.sv
module alt_lookup_engine
    import alt_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NPORTS = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    input  logic                 lk_valid,
    input  logic [MAC_W-1:0]     lk_mac,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [IDX_W-1:0]     res_index,
    output logic [NPORTS-1:0]    res_mask
);

    logic [IDX_W-1:0]  st_rd_idx;
    entry_t            st_rd_entry;
    logic              st_we;
    logic [IDX_W-1:0]  st_wr_idx;
    entry_t            st_wr_entry;
    logic              wipe_en;
    logic [IDX_W-1:0]  wipe_idx;
    logic              lookup_en;
    logic [NPORTS-1:0] port_fwd;
    entry_t            table_q [DEPTH];
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    entry_t            hit_entry;
    logic [NPORTS-1:0] dest_mask;
    logic [NPORTS-1:0] next_mask;

    alt_ctrl #(.DEPTH(DEPTH), .NPORTS(NPORTS)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .st_rd_idx  (st_rd_idx),
        .st_rd_entry(st_rd_entry),
        .st_we      (st_we),
        .st_wr_idx  (st_wr_idx),
        .st_wr_entry(st_wr_entry),
        .wipe_en    (wipe_en),
        .wipe_idx   (wipe_idx),
        .lookup_en  (lookup_en),
        .port_fwd   (port_fwd)
    );

    alt_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .we      (st_we),
        .wr_idx  (st_wr_idx),
        .wr_entry(st_wr_entry),
        .wipe_en (wipe_en),
        .wipe_idx(wipe_idx),
        .rd_idx  (st_rd_idx),
        .rd_entry(st_rd_entry),
        .table_q (table_q)
    );

    alt_search #(.DEPTH(DEPTH)) search_i (
        .table_q  (table_q),
        .mac      (lk_mac),
        .enable   (lookup_en),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_entry(hit_entry)
    );

    // destination set before the forwarding filter
    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            if (entry_is_group(hit_entry)) begin
                dest_mask[p] = entry_mc_mask(hit_entry)[p[1:0]];
            end else begin
                dest_mask[p] = !entry_uc_blocked(hit_entry) &&
                               (entry_uc_port(hit_entry) == p[1:0]);
            end
        end
        next_mask = hit ? (dest_mask & port_fwd) : port_fwd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
            res_mask  <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit   <= hit;
                res_index <= hit_idx;
                res_mask  <= next_mask;
            end
        end
    end

    // R5: one-cycle result latency, no spurious results
    assert_result_follows_R5: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);
    // R9: only forwarding ports appear in a result
    assert_forward_only_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_mask & ~$past(port_fwd)) == '0));
    // R10: a miss floods to every forwarding port
    assert_flood_on_miss_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_mask == $past(port_fwd)));
    // R10: lookups while disabled never hit
    assert_disabled_misses_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(lookup_en)) |-> !res_hit);

endmodule

// File: tb/alt_lookup_engine_tb_top.sv
module alt_lookup_engine_tb_top;

    localparam int DEPTH  = 16;
    localparam int NPORTS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        res_valid;
    logic        res_hit;
    logic [3:0]  res_index;
    logic [2:0]  res_mask;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    alt_lookup_engine #(.DEPTH(DEPTH), .NPORTS(NPORTS)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_mac(lk_mac),
        .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index), .res_mask(res_mask)
    );

    localparam logic [47:0] MAC_A = 48'h02AA_0000_0001;
    localparam logic [47:0] MAC_B = 48'h02BB_0000_0002;
    localparam logic [47:0] MAC_C = 48'h0100_5E00_0001;
    localparam logic [47:0] MAC_D = 48'h02DD_0000_0004;
    localparam logic [47:0] MAC_E = 48'h02EE_0000_0005;
    localparam logic [47:0] MAC_F = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MAC_G = 48'h0277_0000_0007;
    localparam logic [47:0] MAC_H = 48'h0288_0000_0008;

    // {mac, hit, index, mask} with ports 0,1 forwarding and port 2 learning
    localparam int NVEC = 7;
    localparam logic [55:0] VECS [NVEC] = '{
        {MAC_A, 1'b1, 4'd0, 3'b010},   // R7 unicast, R6 lowest of duplicates
        {MAC_B, 1'b1, 4'd2, 3'b000},   // R6 kind 2 skipped, R9 port 2 filtered
        {MAC_C, 1'b1, 4'd3, 3'b011},   // R8 multicast mask, R9 filter
        {MAC_D, 1'b1, 4'd5, 3'b000},   // R7 blocked
        {MAC_E, 1'b0, 4'd0, 3'b011},   // R6 free entry never matches, R10 flood
        {MAC_F, 1'b0, 4'd0, 3'b011},   // R10 flood on absent address
        {MAC_G, 1'b1, 4'd7, 3'b000}    // R7 port field out of range
    };

    task automatic check(string tag, logic [71:0] got, logic [71:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic put(int idx, logic [68:0] e);
        wr(4'd2, {27'b0, e[68:64]});
        wr(4'd3, e[63:32]);
        wr(4'd4, e[31:0]);
        wr(4'd1, 32'h8000_0000 | 32'(idx));
    endtask

    task automatic look(logic [47:0] m);
        lk_valid = 1'b1; lk_mac = m;
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0;
        #1;
    endtask

    function automatic logic [68:0] uc(logic [1:0] kind, logic [47:0] m, logic [1:0] port, logic blk);
        logic [68:0] e = '0;
        e[47:0] = m; e[61:60] = kind; e[67:66] = port; e[65] = blk;
        return e;
    endfunction

    function automatic logic [68:0] mc(logic [1:0] kind, logic [47:0] m, logic [2:0] msk);
        logic [68:0] e = '0;
        e[47:0] = m; e[61:60] = kind; e[68:66] = msk;
        return e;
    endfunction

    initial begin : watchdog
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        check("R1 res_valid", 72'(res_valid), 72'd0);
        rd(4'd0, d); check("R1 global", 72'(d), 72'd0);
        rd(4'd3, d); check("R1 word1", 72'(d), 72'd0);
        rd(4'd8, d); check("R1 port0 state", 72'(d), 72'd0);
        wr(4'd1, 32'd0);
        rd(4'd4, d); check("R1 entry0 free", 72'(d), 72'd0);

        // R2 store / R3 reload
        put(9, {5'h15, 32'h3456_789A, 32'hBCDE_F012});
        wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 0); wr(4'd4, 0);
        wr(4'd1, 32'd9);
        rd(4'd2, d); check("R3 word0 reload", 72'(d), 72'h15);
        rd(4'd3, d); check("R2 word1 stored", 72'(d), 72'h3456_789A);
        rd(4'd4, d); check("R2 word2 stored", 72'(d), 72'hBCDE_F012);

        // R4 out-of-range index
        wr(4'd1, 32'd20);
        rd(4'd3, d); check("R4 reload ignored", 72'(d), 72'h3456_789A);
        wr(4'd1, 32'h8000_0014);
        wr(4'd1, 32'd4);
        rd(4'd3, d); check("R4 store ignored", 72'(d), 72'd0);
        put(9, 69'd0);

        // table and port setup
        wr(4'd0, 32'h8000_0000);
        wr(4'd8, 32'd3); wr(4'd9, 32'd3); wr(4'd10, 32'd2);
        rd(4'd10, d); check("R9 port2 state reads back", 72'(d), 72'd2);
        put(0, uc(2'd1, MAC_A, 2'd1, 1'b0));
        put(1, uc(2'd2, MAC_B, 2'd0, 1'b0));
        put(2, uc(2'd3, MAC_B, 2'd2, 1'b0));
        put(3, mc(2'd1, MAC_C, 3'b111));
        put(4, uc(2'd1, MAC_A, 2'd0, 1'b0));
        put(5, uc(2'd1, MAC_D, 2'd0, 1'b1));
        put(6, uc(2'd0, MAC_E, 2'd0, 1'b0));
        put(7, uc(2'd1, MAC_G, 2'd3, 1'b0));

        for (int i = 0; i < NVEC; i++) begin
            look(VECS[i][55:8]);
            check("R5 valid after lookup", 72'(res_valid), 72'd1);
            check("R6 hit", 72'(res_hit), 72'(VECS[i][7]));
            if (VECS[i][7]) check("R6 index", 72'(res_index), 72'(VECS[i][6:3]));
            check("R7 R8 R9 mask", 72'(res_mask), 72'(VECS[i][2:0]));
        end
        @(negedge clk); #1;
        check("R5 valid drops", 72'(res_valid), 72'd0);

        // R9 port 2 moved to forwarding
        wr(4'd10, 32'd3);
        look(MAC_B); check("R9 unicast port2", 72'(res_mask), 72'b100);
        look(MAC_C); check("R8 multicast all", 72'(res_mask), 72'b111);

        // R12 VLAN-aware bit is inert
        wr(4'd0, 32'h8000_0004);
        rd(4'd0, d); check("R12 vlan bit", 72'(d), 72'h8000_0004);
        look(MAC_A); check("R12 lookup unchanged", 72'({res_hit, res_mask}), 72'b1010);

        // R10 disabled lookups miss
        wr(4'd0, 32'h0);
        look(MAC_A); check("R10 disabled miss", 72'({res_hit, res_mask}), 72'b0111);

        // R11 wipe
        wr(4'd0, 32'hC000_0000);
        rd(4'd0, d); check("R11 busy at start", 72'(d[30]), 72'd1);
        put(0, uc(2'd1, MAC_H, 2'd0, 1'b0));
        repeat (DEPTH - 5) @(negedge clk);
        rd(4'd0, d); check("R11 busy before end", 72'(d[30]), 72'd1);
        @(negedge clk);
        rd(4'd0, d); check("R11 idle after DEPTH", 72'(d[30]), 72'd0);
        look(MAC_A); check("R11 wiped entry misses", 72'({res_hit, res_mask}), 72'b0111);
        look(MAC_H); check("R11 store during wipe ignored", 72'(res_hit), 72'd0);
        wr(4'd1, 32'd3);
        rd(4'd3, d); check("R11 kind freed", 72'(d[29:28]), 72'd0);
        rd(4'd4, d); check("R11 address kept", 72'(d), 72'(MAC_C[31:0]));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule